// File: doc/BRIEF.md
# Page-Granular Bank Mapper

This block sits beside a 6502-style processor bus and lets software reach a large external memory through small windows of 256 bytes. It does not use registers of its own. It watches ordinary stores to a few fixed zero-page addresses. Each such store lands in console RAM as usual, and the block keeps a copy of the byte as the page number for one window. Window `i` covers CPU page `WIN_PAGE + i`, which is `$7C00–$7CFF` and `$7D00–$7DFF` by default. Its page number is loaded by a store to `SNOOP_ADDR + i`, which is `$FC` and `$FD` by default.

When the processor reads inside a window, the block forms a 17-bit physical address. That address is the base `$10000`, plus the latched page times 256, plus the low byte of the CPU address. For such reads it also raises the external memory's enable. With the windows set to consecutive pages, an indexed read that runs past the end of the first window continues on the next page of the same memory without any help. Software can therefore treat a 64 KiB structure as an 8-bit page plus an 8-bit offset.

Top module: `pgmap_top`

## Requirements
- R1: After a synchronous active-low reset, every page latch is zero. A read at `$7C10` therefore maps to `$10010`, and a read at `$7D20` maps to `$10020`.
- R2: A write to address `$00FC` loads the data byte into the page latch of the `$7C00–$7CFF` window.
- R3: A write to address `$00FD` loads the data byte into the page latch of the `$7D00–$7DFF` window, and leaves the other latch unchanged.
- R4: Inside a window, `mem_addr = $10000 + page*256 + cpu_addr[7:0]`, with `page` taken from that window's latch.
- R5: A latch loads only on the first clock edge that sees M2 low after M2 was high, and only if the captured cycle was a write (R/W low). A write with M2 still high, or a read of a snooped address, leaves the latch unchanged.
- R6: Only an exact 16-bit match loads a latch. Stores to mirrors such as `$08FC` and `$01FC`, or to a nearby address such as `$00FE`, change nothing.
- R7: `mem_ce` is high only when R/W is high, M2 is high and the address lies in `$7C00–$7DFF`. It stays low for writes into a window, for reads at `$7BFF` or `$7E00`, and whenever M2 is low.
- R8: When the two latches hold consecutive pages p and p+1, a read at `$7CFF` and a read at `$7D00` produce physical addresses that differ by exactly one.
- R9: Outside the windows, `mem_addr` is zero.
- R10: A read issued in the bus cycle right after a snooped store is translated with the newly stored page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than M2 |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU data bus, observed only |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_m2 | input | 1 | CPU phase-2 clock; data is valid while high |
| mem_addr | output | 17 | Physical address for the external memory |
| mem_ce | output | 1 | External memory enable, active high |

## Verification
Two functions can land in the same clock edge: a latch load from a snooped store, and translation of the address of the next bus cycle. The bench ends a store to `$00FD` by dropping M2 and putting a window read address on the bus in the same step. This makes the commit edge the first edge that sees the new address. Just after that edge, `mem_addr` must already carry the new page while `mem_ce` stays low. When M2 rises again, the enable must go high with the same address.

// File: rtl/pgmap_pkg.sv
// Package: shared widths and the captured-bus record for the page mapper.
// Assumes a 6502-style bus: 16-bit address, 8-bit data, R/W high = read.
package pgmap_pkg;

    localparam int CPU_AW = 16;
    localparam int CPU_DW = 8;
    localparam int PAGE_W = 8;

    typedef struct packed {
        logic [CPU_AW-1:0] addr;
        logic [CPU_DW-1:0] data;
        logic              rw;
    } cpu_bus_t;

endpackage

// File: rtl/pgmap_bus_snoop.sv
// Module: records the bus while M2 is high and raises a one-clock commit
// strobe on the first clock that sees M2 low after it was high.
// Assumes clk is much faster than M2 and that the bus is stable during M2 high.
module pgmap_bus_snoop
    import pgmap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic [CPU_DW-1:0]    cpu_wdata,
    input  logic                 cpu_rw,
    input  logic                 cpu_m2,
    output logic                 commit,
    output cpu_bus_t             cap
);

    logic m2_q;

    // Purpose: delayed copy of M2 for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) m2_q <= 1'b0;
        else        m2_q <= cpu_m2;
    end

    // Purpose: keep the most recent bus state seen while M2 was high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap <= '{addr: '0, data: '0, rw: 1'b1};
        end else if (cpu_m2) begin
            cap.addr <= cpu_addr;
            cap.data <= cpu_wdata;
            cap.rw   <= cpu_rw;
        end
    end

    // Purpose: flag the falling edge of M2.
    always_comb commit = m2_q && !cpu_m2;

    // R5: a commit cannot repeat on the next clock
    p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

endmodule

// File: rtl/pgmap_page_regs.sv
// Module: one page latch per window, each loaded by an exact-address store.
// Assumes window i is loaded by a store to SNOOP_ADDR + i.
module pgmap_page_regs
    import pgmap_pkg::*;
#(
    parameter int NUM_WIN    = 2,
    parameter int SNOOP_ADDR = 16'h00FC
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  cpu_bus_t                      cap,
    output logic [NUM_WIN-1:0][PAGE_W-1:0] pages
);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam logic [CPU_AW-1:0] MY_ADDR = CPU_AW'(SNOOP_ADDR + i);
        logic hit_store;

        // Purpose: decode a committed write to this window's snoop address.
        always_comb hit_store = commit && !cap.rw && (cap.addr == MY_ADDR);

        // Purpose: hold the page number for this window.
        always_ff @(posedge clk) begin
            if (!rst_n)         pages[i] <= '0;
            else if (hit_store) pages[i] <= cap.data;
        end

        // R1: reset leaves the latch at page zero
        p_page_reset_r1: assert property (@(posedge clk)
            !rst_n |=> pages[i] == '0);

        // R5: a latch only changes after a committed write cycle
        p_page_change_on_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pages[i] != $past(pages[i])) |-> $past(commit && !cap.rw));
    end

endmodule

// File: rtl/pgmap_xlate.sv
// Module: decodes the window hit, selects the window's page and forms the
// physical address and the memory enable. Purely combinational.
// Assumes WIN_PAGE + NUM_WIN <= 256 and that the low byte of PHYS_BASE is zero.
module pgmap_xlate
    import pgmap_pkg::*;
#(
    parameter int          NUM_WIN   = 2,
    parameter int          WIN_PAGE  = 8'h7C,
    parameter int          PHYS_W    = 17,
    parameter int unsigned PHYS_BASE = 32'h0001_0000
) (
    input  logic [CPU_AW-1:0]              cpu_addr,
    input  logic                           cpu_rw,
    input  logic                           cpu_m2,
    input  logic [NUM_WIN-1:0][PAGE_W-1:0] pages,
    output logic [PHYS_W-1:0]              mem_addr,
    output logic                           mem_ce
);

    localparam logic [PAGE_W-1:0] WP   = PAGE_W'(WIN_PAGE);
    localparam logic [PHYS_W-1:0] BASE = PHYS_W'(PHYS_BASE);

    logic [PAGE_W-1:0] rel_page;
    logic              hit;
    logic [PAGE_W-1:0] sel_page;
    logic [PHYS_W-1:0] offset;

    // Purpose: find which window, if any, the CPU page falls into.
    always_comb begin
        rel_page = cpu_addr[15:8] - WP;
        hit      = rel_page < PAGE_W'(NUM_WIN);
    end

    // Purpose: pick the page latch of the window that was hit.
    always_comb begin
        sel_page = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (rel_page == PAGE_W'(i)) sel_page = pages[i];
        end
    end

    // Purpose: build the physical address and the read enable.
    always_comb begin
        offset   = PHYS_W'({sel_page, cpu_addr[7:0]});
        mem_addr = hit ? (BASE + offset) : '0;
        mem_ce   = hit && cpu_rw && cpu_m2;
    end

    // R7: the enable never goes high for a write or with M2 low
    always_comb begin
        p_ce_read_only_r7: assert (!mem_ce || (cpu_rw && cpu_m2));
    end

    // R4: the low byte of a translated address follows the CPU address
    always_comb begin
        p_low_byte_kept_r4: assert (!hit || mem_addr[7:0] == cpu_addr[7:0]);
    end

endmodule

// File: rtl/pgmap_top.sv
// Module: page-granular bank mapper top. It snoops zero-page stores into the
// page latches and translates window reads to physical addresses.
// Assumes one clock domain, with M2 and the bus sampled on clk.
module pgmap_top
    import pgmap_pkg::*;
#(
    parameter int          NUM_WIN    = 2,
    parameter int          SNOOP_ADDR = 16'h00FC,
    parameter int          WIN_PAGE   = 8'h7C,
    parameter int          PHYS_W     = 17,
    parameter int unsigned PHYS_BASE  = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_rw,
    input  logic              cpu_m2,
    output logic [PHYS_W-1:0] mem_addr,
    output logic              mem_ce
);

    logic                          commit;
    cpu_bus_t                      cap;
    logic [NUM_WIN-1:0][PAGE_W-1:0] pages;

    pgmap_bus_snoop u_snoop (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rw    (cpu_rw),
        .cpu_m2    (cpu_m2),
        .commit    (commit),
        .cap       (cap)
    );

    pgmap_page_regs #(
        .NUM_WIN    (NUM_WIN),
        .SNOOP_ADDR (SNOOP_ADDR)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .cap    (cap),
        .pages  (pages)
    );

    pgmap_xlate #(
        .NUM_WIN   (NUM_WIN),
        .WIN_PAGE  (WIN_PAGE),
        .PHYS_W    (PHYS_W),
        .PHYS_BASE (PHYS_BASE)
    ) u_xlate (
        .cpu_addr (cpu_addr),
        .cpu_rw   (cpu_rw),
        .cpu_m2   (cpu_m2),
        .pages    (pages),
        .mem_addr (mem_addr),
        .mem_ce   (mem_ce)
    );

endmodule

// File: tb/pgmap_top_test.sv
module pgmap_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rw = 1'b1;
    logic        cpu_m2 = 1'b0;
    logic [16:0] mem_addr;
    logic        mem_ce;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pgmap_top uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rw(cpu_rw), .cpu_m2(cpu_m2), .mem_addr(mem_addr), .mem_ce(mem_ce)
    );

    // Each entry: {page for $7C window, page for $7D window, offset}
    localparam logic [23:0] VEC [0:7] = '{
        24'h00_00_00, 24'hFF_FF_FF, 24'h12_34_56, 24'h80_81_7F,
        24'h01_00_80, 24'hA5_5A_01, 24'hFE_FF_FE, 24'h3C_C3_C3
    };

    function automatic logic [16:0] phys(input logic [7:0] pg, input logic [7:0] off);
        return 17'h10000 + {1'b0, pg, off};
    endfunction

    task automatic expect_out(input string req, input logic [16:0] ea, input logic ec);
        checks++;
        if (mem_addr !== ea || mem_ce !== ec) begin
            failures++;
            $display("FAIL %s actual addr=%h ce=%b expected addr=%h ce=%b",
                     req, mem_addr, mem_ce, ea, ec);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_rw = 1'b0; cpu_m2 = 1'b1;
        repeat (2) @(negedge clk);
        cpu_m2 = 1'b0;
        @(negedge clk);
        cpu_rw = 1'b1;
    endtask

    task automatic bus_read(input string req, input logic [15:0] a,
                            input logic [16:0] ea, input logic ec);
        @(negedge clk);
        cpu_addr = a; cpu_rw = 1'b1; cpu_m2 = 1'b1;
        #1 expect_out(req, ea, ec);
        @(negedge clk);
        cpu_m2 = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read("R1", 16'h7C10, 17'h10010, 1'b1);
        bus_read("R1", 16'h7D20, 17'h10020, 1'b1);

        // Table walk: R2, R3 and R4 over the latch and offset patterns
        for (int i = 0; i < 8; i++) begin
            bus_write(16'h00FC, VEC[i][23:16]);
            bus_write(16'h00FD, VEC[i][15:8]);
            bus_read("R2/R4", {8'h7C, VEC[i][7:0]}, phys(VEC[i][23:16], VEC[i][7:0]), 1'b1);
            bus_read("R3/R4", {8'h7D, VEC[i][7:0]}, phys(VEC[i][15:8], VEC[i][7:0]), 1'b1);
        end

        // R4: random latch values and offsets
        for (int i = 0; i < 12; i++) begin
            logic [7:0] p0, p1, off;
            p0 = 8'($urandom); p1 = 8'($urandom); off = 8'($urandom);
            bus_write(16'h00FC, p0);
            bus_write(16'h00FD, p1);
            bus_read("R4", {8'h7C, off}, phys(p0, off), 1'b1);
            bus_read("R4", {8'h7D, off}, phys(p1, off), 1'b1);
        end

        // R3: a write to $FD leaves the $7C window alone
        bus_write(16'h00FC, 8'h21);
        bus_write(16'h00FD, 8'h99);
        bus_read("R3", 16'h7C05, phys(8'h21, 8'h05), 1'b1);

        // R6: mirrors and a neighbouring address do nothing
        bus_write(16'h08FC, 8'hAA);
        bus_write(16'h01FC, 8'hAB);
        bus_write(16'h00FE, 8'hAC);
        bus_write(16'h10FD, 8'hAD);
        bus_read("R6", 16'h7C05, phys(8'h21, 8'h05), 1'b1);
        bus_read("R6", 16'h7D05, phys(8'h99, 8'h05), 1'b1);

        // R5: store held with M2 high is not yet loaded; a read of $FC loads nothing
        @(negedge clk);
        cpu_addr = 16'h00FC; cpu_wdata = 8'h55; cpu_rw = 1'b0; cpu_m2 = 1'b1;
        repeat (3) @(negedge clk);
        cpu_addr = 16'h7C07; cpu_rw = 1'b1;
        #1 expect_out("R5", phys(8'h21, 8'h07), 1'b1);
        @(negedge clk);
        cpu_m2 = 1'b0;
        @(negedge clk);
        #1 expect_out("R5", phys(8'h21, 8'h07), 1'b0);
        bus_read("R5", 16'h00FC, 17'h0, 1'b0);
        bus_read("R5", 16'h7C07, phys(8'h21, 8'h07), 1'b1);

        // R7: enable qualifiers
        bus_read("R7", 16'h7BFF, 17'h0, 1'b0);
        bus_read("R7", 16'h7E00, 17'h0, 1'b0);
        @(negedge clk);
        cpu_addr = 16'h7C40; cpu_rw = 1'b0; cpu_m2 = 1'b1; cpu_wdata = 8'h11;
        #1 expect_out("R7", phys(8'h21, 8'h40), 1'b0);
        @(negedge clk);
        cpu_m2 = 1'b0; cpu_rw = 1'b1;
        #1 expect_out("R7", phys(8'h21, 8'h40), 1'b0);
        bus_read("R7", 16'h7C40, phys(8'h21, 8'h40), 1'b1);

        // R9: outside windows the address is zero
        bus_read("R9", 16'h0000, 17'h0, 1'b0);
        bus_read("R9", 16'hFFFF, 17'h0, 1'b0);

        // R8: consecutive pages make a contiguous run across the boundary
        bus_write(16'h00FC, 8'h4F);
        bus_write(16'h00FD, 8'h50);
        bus_read("R8", 16'h7CFF, 17'h14FFF, 1'b1);
        bus_read("R8", 16'h7D00, 17'h15000, 1'b1);

        // R10: commit and translation of the next address on the same edge
        @(negedge clk);
        cpu_addr = 16'h00FD; cpu_wdata = 8'h80; cpu_rw = 1'b0; cpu_m2 = 1'b1;
        repeat (2) @(negedge clk);
        cpu_m2 = 1'b0; cpu_addr = 16'h7D11; cpu_rw = 1'b1;
        @(posedge clk);
        #1 expect_out("R10", 17'h18011, 1'b0);
        @(negedge clk);
        cpu_m2 = 1'b1;
        #1 expect_out("R10", 17'h18011, 1'b1);
        @(negedge clk);
        cpu_m2 = 1'b0;

        // R1: reset mid-run clears both latches
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus_read("R1", 16'h7D33, 17'h10033, 1'b1);
        bus_read("R1", 16'h7C44, 17'h10044, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule